// File: doc/BRIEF.md
# Wiper Setting Store Controller

This block keeps a sixteen-entry array of persistent 16-bit words next to two live wiper registers. Slots 0 and 1 hold the saved settings of wiper 0 and wiper 1. Slots 2 to 14 are general words for user data. Slot 15 holds a factory tolerance word and cannot be written. The tolerance word is in sign-magnitude form: bit 15 is the sign (1 means negative), bits 14..8 are the whole percent, and bits 7..0 are the fraction in steps of 1/256.

Commands arrive over a valid/ready handshake. Each command carries an opcode, an address, a wiper select and a data word. The command set is: save a wiper, restore one wiper or both, load a wiper directly, write a word and read a word. After reset, a two-cycle boot step copies slot 0 into wiper 0 and then slot 1 into wiper 1. Only after that does the block raise `cmd_ready`. A dedicated preset input restores both wipers at any time after boot.

An array write is modelled with a fixed latency. The block reports busy for `WR_CYCLES` cycles after each write, and rejects any command that arrives during that time. Restoring a single wiper puts the block into a read-power mode. Only an accepted no-op command clears that mode.

Top module: `sstore_ctrl`

## Requirements
- R1: While reset is held, `cmd_ready`, both wipers, `busy`, `err`, `rd_valid` and `rd_mode` are 0. At the first edge after reset is released, wiper 0 takes bits 9..0 of slot 0. At the second edge, wiper 1 takes slot 1. `cmd_ready` then rises and stays high.
- R2: Opcode 6 (set wiper) loads the selected wiper (`cmd_wsel` 0 or 1) with `cmd_data[9:0]` at the accepting edge.
- R3: Opcode 2 (save wiper) writes the selected wiper, zero-extended, to slot `cmd_wsel`. `busy` is then high for `WR_CYCLES` cycles, starting after the accepting edge.
- R4: Opcode 3 (write word) writes `cmd_data` to slot `cmd_addr` for addresses 0..14, and raises `busy` for `WR_CYCLES` cycles.
- R5: Opcode 3 with address 15 changes nothing. `busy` stays low and slot 15 keeps its value.
- R6: Opcode 4 (read word) sets `rd_valid` high for one cycle after the accepting edge, with `rd_data` equal to slot `cmd_addr`. Address 15 returns `CAL_WORD` (default 0x1C0F, meaning +28 + 15/256 percent).
- R7: Opcode 1 (restore one) copies slot `cmd_wsel` into the selected wiper and sets `rd_mode`.
- R8: Opcode 5 (restore both) copies slots 0 and 1 into both wipers and leaves `rd_mode` unchanged.
- R9: `rd_mode` falls only after an accepted, non-rejected opcode 0 (no-op). No other opcode clears it.
- R10: A command presented while `busy` is high has no effect. `err` is high for the one cycle after it.
- R11: After boot, `preset_req` restores both wipers at the next edge, even while busy. A command in that same cycle is rejected with `err`.
- R12: Opcodes 7..15 are accepted and change no output or state. They do not raise `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | High once the boot restore has finished |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | 4 | Word address for write and read |
| cmd_wsel | input | 1 | Wiper select |
| cmd_data | input | 16 | Write data or wiper value |
| preset_req | input | 1 | Restore both wipers from their slots |
| wiper0 | output | 10 | Live wiper 0 setting |
| wiper1 | output | 10 | Live wiper 1 setting |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 16 | Read result |
| busy | output | 1 | Array write in progress |
| err | output | 1 | Rejected-command pulse |
| rd_mode | output | 1 | Read-power mode flag |

## Verification
Two pairs of events can fall in the same cycle. The first is the preset restore with a command. The bench raises `preset_req` in the same cycle as a set-wiper command, then checks that `err` pulses and that the wiper shows the restored slot value rather than the command's data. The second is the preset restore during a write's busy window. The bench starts a word write and presets on the next cycle, then checks that both wipers are restored while `busy` continues to count down. A behavioural reference model runs alongside and judges every output on every clock.

// File: rtl/sstore_pkg.sv
package sstore_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [3:0] OP_NOP       = 4'd0;
  localparam logic [3:0] OP_LOAD_ONE  = 4'd1;
  localparam logic [3:0] OP_STORE_ONE = 4'd2;
  localparam logic [3:0] OP_PUT_USER  = 4'd3;
  localparam logic [3:0] OP_GET_USER  = 4'd4;
  localparam logic [3:0] OP_LOAD_ALL  = 4'd5;
  localparam logic [3:0] OP_SET_WIPER = 4'd6;

  typedef enum logic [1:0] {BOOT_W0, BOOT_W1, BOOT_DONE} boot_e;
endpackage

// File: rtl/sstore_array.sv
module sstore_array
  import sstore_pkg::*;
#(
  parameter int               WR_CYCLES = 6,
  parameter logic [WORD_W-1:0] W0_INIT  = 16'h0155,
  parameter logic [WORD_W-1:0] W1_INIT  = 16'h0200,
  parameter logic [WORD_W-1:0] CAL_WORD = 16'h1C0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword,
  output logic [WORD_W-1:0] slot0,
  output logic [WORD_W-1:0] slot1,
  output logic              wr_fire,
  output logic              busy
);
  localparam int RO_ADDR = DEPTH - 1;
  localparam int CNT_W   = $clog2(WR_CYCLES + 1);

  logic [WORD_W-1:0] mem [RO_ADDR];
  logic [CNT_W-1:0]  cnt;

  function automatic logic [WORD_W-1:0] init_word(input int idx);
    if (idx == 0) return W0_INIT;
    if (idx == 1) return W1_INIT;
    return '0;
  endfunction

  assign wr_fire = we && (waddr != ADDR_W'(RO_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RO_ADDR; i++) mem[i] <= init_word(i);
    end else if (wr_fire) begin
      for (int i = 0; i < RO_ADDR; i++)
        if (waddr == ADDR_W'(i)) mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (wr_fire)      cnt <= CNT_W'(WR_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy  = (cnt != '0);
  assign slot0 = mem[0];
  assign slot1 = mem[1];

  always_comb begin
    rword = CAL_WORD;
    for (int i = 0; i < RO_ADDR; i++)
      if (raddr == ADDR_W'(i)) rword = mem[i];
  end
endmodule

// File: rtl/sstore_boot.sv
module sstore_boot
  import sstore_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic step0,
  output logic step1,
  output logic done
);
  boot_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= BOOT_W0;
    else begin
      case (state)
        BOOT_W0: state <= BOOT_W1;
        BOOT_W1: state <= BOOT_DONE;
        default: state <= BOOT_DONE;
      endcase
    end
  end

  assign step0 = (state == BOOT_W0);
  assign step1 = (state == BOOT_W1);
  assign done  = (state == BOOT_DONE);
endmodule

// File: rtl/sstore_ctrl.sv
module sstore_ctrl
  import sstore_pkg::*;
#(
  parameter int               WIPER_W   = 10,
  parameter int               WR_CYCLES = 6,
  parameter logic [WORD_W-1:0] W0_INIT  = 16'h0155,
  parameter logic [WORD_W-1:0] W1_INIT  = 16'h0200,
  parameter logic [WORD_W-1:0] CAL_WORD = 16'h1C0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               cmd_wsel,
  input  logic [WORD_W-1:0]  cmd_data,
  input  logic               preset_req,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  output logic               busy,
  output logic               err,
  output logic               rd_mode
);
  function automatic logic [WIPER_W-1:0] to_wiper(input logic [WORD_W-1:0] w);
    return w[WIPER_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] to_word(input logic [WIPER_W-1:0] v);
    return WORD_W'(v);
  endfunction

  logic boot_step0, boot_step1, boot_done;
  logic accept, take, reject, preset_hit, wr_fire;
  logic we;
  logic [ADDR_W-1:0] waddr;
  logic [WORD_W-1:0] wdata, rword, slot0, slot1, slot_sel;
  logic [WIPER_W-1:0] w_sel_live;

  sstore_boot u_boot (
    .clk(clk), .rst_n(rst_n),
    .step0(boot_step0), .step1(boot_step1), .done(boot_done)
  );

  assign cmd_ready  = boot_done;
  assign accept     = cmd_valid && boot_done;
  assign preset_hit = preset_req && boot_done;
  assign reject     = accept && (busy || preset_req);
  assign take       = accept && !busy && !preset_req;

  assign slot_sel   = cmd_wsel ? slot1 : slot0;
  assign w_sel_live = cmd_wsel ? wiper1 : wiper0;

  always_comb begin
    we    = 1'b0;
    waddr = cmd_addr;
    wdata = cmd_data;
    if (take && cmd_op == OP_STORE_ONE) begin
      we    = 1'b1;
      waddr = ADDR_W'(cmd_wsel);
      wdata = to_word(w_sel_live);
    end else if (take && cmd_op == OP_PUT_USER) begin
      we = 1'b1;
    end
  end

  sstore_array #(
    .WR_CYCLES(WR_CYCLES), .W0_INIT(W0_INIT), .W1_INIT(W1_INIT), .CAL_WORD(CAL_WORD)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(cmd_addr), .rword(rword), .slot0(slot0), .slot1(slot1),
    .wr_fire(wr_fire), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper0 <= '0;
      wiper1 <= '0;
    end else if (boot_step0) begin
      wiper0 <= to_wiper(slot0);
    end else if (boot_step1) begin
      wiper1 <= to_wiper(slot1);
    end else if (preset_hit) begin
      wiper0 <= to_wiper(slot0);
      wiper1 <= to_wiper(slot1);
    end else if (take) begin
      case (cmd_op)
        OP_SET_WIPER: begin
          if (cmd_wsel) wiper1 <= to_wiper(cmd_data);
          else          wiper0 <= to_wiper(cmd_data);
        end
        OP_LOAD_ONE: begin
          if (cmd_wsel) wiper1 <= to_wiper(slot_sel);
          else          wiper0 <= to_wiper(slot_sel);
        end
        OP_LOAD_ALL: begin
          wiper0 <= to_wiper(slot0);
          wiper1 <= to_wiper(slot1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             rd_mode <= 1'b0;
    else if (take && cmd_op == OP_LOAD_ONE) rd_mode <= 1'b1;
    else if (take && cmd_op == OP_NOP)      rd_mode <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      err      <= reject;
      rd_valid <= take && cmd_op == OP_GET_USER;
      if (take && cmd_op == OP_GET_USER) rd_data <= rword;
    end
  end
endmodule

// File: rtl/sstore_chk.sv
module sstore_chk
  import sstore_pkg::*;
#(
  parameter int               WIPER_W  = 10,
  parameter logic [WORD_W-1:0] CAL_WORD = 16'h1C0F
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [3:0]         cmd_op,
  input logic [ADDR_W-1:0]  cmd_addr,
  input logic               preset_req,
  input logic               busy,
  input logic               err,
  input logic               rd_valid,
  input logic [WORD_W-1:0]  rd_data,
  input logic               rd_mode,
  input logic [WIPER_W-1:0] wiper0,
  input logic [WIPER_W-1:0] wiper1,
  input logic [WORD_W-1:0]  slot0,
  input logic [WORD_W-1:0]  slot1,
  input logic               take,
  input logic               wr_fire
);
  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> cmd_ready);

  assert_save_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_STORE_ONE) |=> busy);

  assert_write_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> busy);

  assert_ro_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_PUT_USER && cmd_addr == 4'hF) |=> !busy);

  assert_cal_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_GET_USER && cmd_addr == 4'hF) |=> (rd_valid && rd_data == CAL_WORD));

  assert_load_sets_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_LOAD_ONE) |=> rd_mode);

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_mode) |-> $past(take && cmd_op == OP_NOP));

  assert_reject_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (busy || preset_req)) |=> err);

  assert_preset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_req && cmd_ready) |=>
      (wiper0 == $past(slot0[WIPER_W-1:0]) && wiper1 == $past(slot1[WIPER_W-1:0])));
endmodule

bind sstore_ctrl sstore_chk #(.WIPER_W(WIPER_W), .CAL_WORD(CAL_WORD)) u_chk (.*);

// File: tb/sstore_ctrl_tb.sv
`timescale 1ns/1ps
module sstore_ctrl_tb;
  localparam int WR = 6;
  localparam logic [15:0] MASK = 16'h03FF;
  localparam logic [15:0] CALV = 16'h1C0F;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_wsel = 0, preset_req = 0;
  logic [3:0] cmd_op = 0, cmd_addr = 0;
  logic [15:0] cmd_data = 0;
  logic cmd_ready, rd_valid, busy, err, rd_mode;
  logic [9:0] wiper0, wiper1;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sstore_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wsel(cmd_wsel), .cmd_data(cmd_data),
    .preset_req(preset_req), .wiper0(wiper0), .wiper1(wiper1), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .err(err), .rd_mode(rd_mode)
  );

  // behavioural reference model
  logic [15:0] m_mem [16];
  logic [15:0] m_w0, m_w1, m_rd;
  int m_boot, m_busy;
  bit m_err, m_rv, m_mode;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_mem[i] = 16'h0;
      m_mem[0] = 16'h0155; m_mem[1] = 16'h0200; m_mem[15] = CALV;
      m_boot = 0; m_busy = 0; m_w0 = 0; m_w1 = 0; m_rd = 0;
      m_err = 0; m_rv = 0; m_mode = 0;
    end else begin
      m_err = 0; m_rv = 0;
      if (m_boot == 0) begin m_w0 = m_mem[0] & MASK; m_boot = 1; end
      else if (m_boot == 1) begin m_w1 = m_mem[1] & MASK; m_boot = 2; end
      else begin
        bit started;
        started = 0;
        if (preset_req) begin m_w0 = m_mem[0] & MASK; m_w1 = m_mem[1] & MASK; end
        if (cmd_valid) begin
          if (m_busy > 0 || preset_req) m_err = 1;
          else case (cmd_op)
            4'd0: m_mode = 0;
            4'd1: begin
              if (cmd_wsel) m_w1 = m_mem[1] & MASK; else m_w0 = m_mem[0] & MASK;
              m_mode = 1;
            end
            4'd2: begin m_mem[cmd_wsel ? 1 : 0] = cmd_wsel ? m_w1 : m_w0; started = 1; end
            4'd3: if (cmd_addr != 4'hF) begin m_mem[cmd_addr] = cmd_data; started = 1; end
            4'd4: begin m_rv = 1; m_rd = m_mem[cmd_addr]; end
            4'd5: begin m_w0 = m_mem[0] & MASK; m_w1 = m_mem[1] & MASK; end
            4'd6: if (cmd_wsel) m_w1 = cmd_data & MASK; else m_w0 = cmd_data & MASK;
            default: ;
          endcase
        end
        if (started) m_busy = WR;
        else if (m_busy > 0) m_busy = m_busy - 1;
      end
    end
  end

  task automatic cmp(input string tag, input string name, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s model %s: actual=%h expected=%h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("R1", "cmd_ready", 16'(cmd_ready), 16'(m_boot == 2));
      cmp("R2", "wiper0", 16'(wiper0), m_w0);
      cmp("R2", "wiper1", 16'(wiper1), m_w1);
      cmp("R3", "busy", 16'(busy), 16'(m_busy > 0));
      cmp("R10", "err", 16'(err), 16'(m_err));
      cmp("R6", "rd_valid", 16'(rd_valid), 16'(m_rv));
      if (m_rv) cmp("R6", "rd_data", rd_data, m_rd);
      cmp("R9", "rd_mode", 16'(rd_mode), 16'(m_mode));
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit v, input logic [3:0] op, input logic [3:0] a,
                       input bit ws, input logic [15:0] d, input bit pre);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wsel = ws; cmd_data = d; preset_req = pre;
    @(negedge clk);
    cmd_valid = 0; preset_req = 0;
  endtask

  task automatic send(input logic [3:0] op, input logic [3:0] a, input bit ws, input logic [15:0] d);
    drive(1, op, a, ws, d, 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 16'(cmd_ready), 0);
    chk("R1 wiper0 in reset", 16'(wiper0), 0);
    chk("R1 busy/err/mode in reset", {13'd0, busy, err, rd_mode}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 boot step wiper0", 16'(wiper0), 16'h0155);
    chk("R1 not ready mid-boot", 16'(cmd_ready), 0);
    @(negedge clk);
    chk("R1 boot step wiper1", 16'(wiper1), 16'h0200);
    chk("R1 ready after boot", 16'(cmd_ready), 1);

    send(4'd6, 0, 0, 16'h02A3);
    chk("R2 set wiper0", 16'(wiper0), 16'h02A3);
    send(4'd6, 0, 1, 16'hF011);
    chk("R2 set wiper1 truncated", 16'(wiper1), 16'h0011);

    send(4'd2, 0, 0, 16'h0);
    chk("R3 busy after save", 16'(busy), 1);
    send(4'd4, 0, 0, 16'h0);
    chk("R10 err on busy command", 16'(err), 1);
    chk("R10 no read while busy", 16'(rd_valid), 0);
    wait_idle();
    send(4'd4, 0, 0, 16'h0);
    chk("R3 saved slot0", rd_data, 16'h02A3);

    send(4'd6, 0, 0, 16'h0001);
    send(4'd1, 0, 0, 16'h0);
    chk("R7 restore one wiper0", 16'(wiper0), 16'h02A3);
    chk("R7 wiper1 untouched", 16'(wiper1), 16'h0011);
    chk("R7 read mode set", 16'(rd_mode), 1);

    send(4'd3, 4'd7, 0, 16'hBEEF);
    chk("R4 busy after word write", 16'(busy), 1);
    wait_idle();
    send(4'd4, 4'd7, 0, 16'h0);
    chk("R4 word readback", rd_data, 16'hBEEF);

    send(4'd3, 4'hF, 0, 16'h0000);
    chk("R5 no busy on slot15 write", 16'(busy), 0);
    send(4'd4, 4'hF, 0, 16'h0);
    chk("R5 slot15 unchanged", rd_data, CALV);
    chk("R6 read valid", 16'(rd_valid), 1);
    chk("R6 tolerance sign", 16'(rd_data[15]), 0);
    chk("R6 tolerance whole percent", 16'(rd_data[14:8]), 16'd28);
    chk("R6 tolerance fraction", 16'(rd_data[7:0]), 16'd15);

    send(4'd9, 4'd2, 1, 16'hFFFF);
    chk("R12 no err", 16'(err), 0);
    chk("R12 wipers unchanged", {6'd0, wiper0}, 16'h02A3);
    chk("R9 mode kept by other opcode", 16'(rd_mode), 1);

    send(4'd6, 0, 0, 16'h03FF);
    send(4'd6, 0, 1, 16'h03FF);
    send(4'd5, 0, 0, 16'h0);
    chk("R8 restore both wiper0", 16'(wiper0), 16'h02A3);
    chk("R8 restore both wiper1", 16'(wiper1), 16'h0200);
    chk("R8 mode unchanged", 16'(rd_mode), 1);

    send(4'd3, 4'd2, 0, 16'h1234);
    send(4'd0, 0, 0, 16'h0);
    chk("R10 nop rejected while busy", 16'(err), 1);
    chk("R9 mode kept after rejected nop", 16'(rd_mode), 1);
    wait_idle();
    send(4'd0, 0, 0, 16'h0);
    chk("R9 nop clears mode", 16'(rd_mode), 0);

    send(4'd6, 0, 0, 16'h00AA);
    send(4'd6, 0, 1, 16'h00BB);
    send(4'd3, 4'd3, 0, 16'h5555);
    drive(0, 0, 0, 0, 0, 1);
    chk("R11 preset during busy wiper0", 16'(wiper0), 16'h02A3);
    chk("R11 preset during busy wiper1", 16'(wiper1), 16'h0200);
    chk("R11 busy continues", 16'(busy), 1);
    chk("R11 no err on plain preset", 16'(err), 0);
    wait_idle();
    send(4'd6, 0, 0, 16'h00CC);
    drive(1, 4'd6, 0, 0, 16'h0055, 1);
    chk("R11 command with preset rejected", 16'(err), 1);
    chk("R11 preset wins wiper0", 16'(wiper0), 16'h02A3);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule